// File: doc/BRIEF.md
# Palette to DAC Index Composer

This block sits in the pixel path of a display controller. Each clock it takes a pixel code and turns it into the 8-bit index that addresses a colour lookup DAC. The low four bits of the code are masked by a per-plane enable and then pick one of sixteen 6-bit palette entries. The top DAC bits are then merged in from a colour-select value. A mode bit decides whether bits 5:4 of the result come from the palette entry or from colour select. In 8-bit pixel mode the palette and colour select are skipped, and the full pixel byte goes straight to the DAC.

While the beam is in the border, a border input replaces the pixel path with the overscan colour. That colour is composed exactly like a palette entry, or passed through whole in 8-bit pixel mode. Two diagnostic bits tap the composed index through a 4-way selector driven by the upper bits of the plane-enable value. The index, the diagnostic bits and a valid strobe all come out one clock after the input.

Top module: `pal_dac_mux`

## Requirements
- R1: While rst_n is low, dac_vld_o, dac_idx_o and diag_o are all zero.
- R2: dac_vld_o equals pix_vld_i from the previous clock, and dac_idx_o and diag_o show the result for the inputs of the previous clock.
- R3: Outside 8-bit mode, with border_i low, palette slot n is selected, where bit k of n is pix_code_i[k] AND plane_en_i[k] for k = 0..3. Slot n is held in pal_flat_i[6n+5:6n].
- R4: With mode_ctl_i = 2'b00 and border_i low, dac_idx_o[5:0] equals the selected palette entry.
- R5: With mode_ctl_i = 2'b10, dac_idx_o[3:0] equals bits 3:0 of the selected entry and dac_idx_o[5:4] equals col_sel_i[1:0].
- R6: Whenever mode_ctl_i[0] is 0, dac_idx_o[7:6] equals col_sel_i[3:2].
- R7: When mode_ctl_i[0] is 1 (8-bit pixel mode) and border_i is low, dac_idx_o equals the 8-bit pix_code_i. The palette, col_sel_i and plane_en_i[3:0] have no effect.
- R8: When border_i is high, ovs_color_i[5:0] takes the place of the palette entry in R4 to R6, and no plane masking is applied. In 8-bit mode, dac_idx_o equals ovs_color_i.
- R9: diag_o is taken from the same composed index that dac_idx_o shows, as {hi, lo}, selected by plane_en_i[5:4]:
  - 0 gives {bit 2, bit 0}
  - 1 gives {bit 5, bit 4}
  - 2 gives {bit 3, bit 1}
  - 3 gives {bit 7, bit 6}

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_vld_i | input | 1 | Pixel strobe |
| pix_code_i | input | 8 | Pixel code; bits 3:0 form the attribute code, all 8 bits are used in 8-bit mode |
| border_i | input | 1 | Selects the overscan colour in place of the pixel |
| pal_flat_i | input | 96 | Sixteen 6-bit palette entries, slot n at bits 6n+5:6n |
| mode_ctl_i | input | 2 | [1] colour select drives DAC bits 5:4; [0] 8-bit pixel mode |
| col_sel_i | input | 4 | Colour select: [3:2] feed DAC bits 7:6, [1:0] feed DAC bits 5:4 when chosen |
| plane_en_i | input | 6 | [3:0] plane masks; [5:4] diagnostic selector |
| ovs_color_i | input | 8 | Overscan (border) colour |
| dac_vld_o | output | 1 | Registered strobe |
| dac_idx_o | output | 8 | Registered DAC index |
| diag_o | output | 2 | Registered diagnostic bit pair |

## Verification
Two functions can act in the same cycle: the overscan substitution and the diagnostic tap. When both are active, diag_o must follow the border colour rather than the masked pixel. The bench provokes this by toggling border_i while it steps through all four diagnostic selectors, in both palette and 8-bit modes. A behavioural model compares dac_idx_o, diag_o and dac_vld_o against the expected values on every clock.

// File: rtl/pal_dac_mux.sv
module pal_dac_mux #(
  parameter int PIX_W  = 8,
  parameter int ENT_W  = 6,
  parameter int PLANES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            pix_vld_i,
  input  logic [PIX_W-1:0]                pix_code_i,
  input  logic                            border_i,
  input  logic [(1<<PLANES)*ENT_W-1:0]    pal_flat_i,
  input  logic [1:0]                      mode_ctl_i,
  input  logic [3:0]                      col_sel_i,
  input  logic [PLANES+1:0]               plane_en_i,
  input  logic [PIX_W-1:0]                ovs_color_i,
  output logic                            dac_vld_o,
  output logic [PIX_W-1:0]                dac_idx_o,
  output logic [1:0]                      diag_o
);
  localparam int ENTRIES = 1 << PLANES;

  logic [ENT_W-1:0] pal [ENTRIES];
  for (genvar g = 0; g < ENTRIES; g++) begin : g_pal
    assign pal[g] = pal_flat_i[g*ENT_W +: ENT_W];
  end

  wire [PLANES-1:0] code_m = pix_code_i[PLANES-1:0] & plane_en_i[PLANES-1:0];
  wire [ENT_W-1:0]  src    = border_i ? ovs_color_i[ENT_W-1:0] : pal[code_m];
  wire [1:0]        mid    = mode_ctl_i[1] ? col_sel_i[1:0] : src[5:4];
  wire [PIX_W-1:0]  raw    = border_i ? ovs_color_i : pix_code_i;
  wire [PIX_W-1:0]  idx_d  = mode_ctl_i[0] ? raw : {col_sel_i[3:2], mid, src[3:0]};

  logic [1:0] diag_d;
  always_comb begin
    case (plane_en_i[PLANES+1:PLANES])
      2'd0:    diag_d = {idx_d[2], idx_d[0]};
      2'd1:    diag_d = {idx_d[5], idx_d[4]};
      2'd2:    diag_d = {idx_d[3], idx_d[1]};
      default: diag_d = {idx_d[7], idx_d[6]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_vld_o <= 1'b0;
      dac_idx_o <= '0;
      diag_o    <= 2'b00;
    end else begin
      dac_vld_o <= pix_vld_i;
      dac_idx_o <= idx_d;
      diag_o    <= diag_d;
    end
  end
endmodule

module pal_dac_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_vld_i,
  input logic [7:0] pix_code_i,
  input logic       border_i,
  input logic [1:0] mode_ctl_i,
  input logic [3:0] col_sel_i,
  input logic [5:0] plane_en_i,
  input logic [7:0] ovs_color_i,
  input logic       dac_vld_o,
  input logic [7:0] dac_idx_o,
  input logic [1:0] diag_o
);
  assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_i |=> dac_vld_o);
  assert_vld_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld_i |=> !dac_vld_o);
  assert_csel_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ctl_i == 2'b10) |=> dac_idx_o[5:4] == $past(col_sel_i[1:0]));
  assert_csel_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ctl_i[0] |=> dac_idx_o[7:6] == $past(col_sel_i[3:2]));
  assert_pix8_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ctl_i[0] && !border_i) |=> dac_idx_o == $past(pix_code_i));
  assert_ovs8_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ctl_i[0] && border_i) |=> dac_idx_o == $past(ovs_color_i));
  assert_diag_sel1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_en_i[5:4] == 2'd1) |=> diag_o == dac_idx_o[5:4]);
  assert_diag_sel3_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_en_i[5:4] == 2'd3) |=> diag_o == dac_idx_o[7:6]);
endmodule

bind pal_dac_mux pal_dac_mux_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pix_vld_i(pix_vld_i), .pix_code_i(pix_code_i),
  .border_i(border_i), .mode_ctl_i(mode_ctl_i), .col_sel_i(col_sel_i),
  .plane_en_i(plane_en_i), .ovs_color_i(ovs_color_i), .dac_vld_o(dac_vld_o),
  .dac_idx_o(dac_idx_o), .diag_o(diag_o)
);

// File: tb/pal_dac_mux_tb_top.sv
module pal_dac_mux_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        pix_vld_i;
  logic [7:0]  pix_code_i;
  logic        border_i;
  logic [95:0] pal_flat_i;
  logic [1:0]  mode_ctl_i;
  logic [3:0]  col_sel_i;
  logic [5:0]  plane_en_i;
  logic [7:0]  ovs_color_i;
  logic        dac_vld_o;
  logic [7:0]  dac_idx_o;
  logic [1:0]  diag_o;

  logic [5:0] pal_m [16];
  always_comb for (int i = 0; i < 16; i++) pal_flat_i[i*6 +: 6] = pal_m[i];

  pal_dac_mux dut_i (.*);

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    armed = 0;
  int    e_idx, e_vld, e_diag;

  function automatic int bitof(int v, int k);
    return (v >> k) & 1;
  endfunction

  function automatic int ref_idx();
    int e, a;
    if (mode_ctl_i[0]) return border_i ? int'(ovs_color_i) : int'(pix_code_i);
    if (border_i) e = ovs_color_i % 64;
    else begin
      a = (pix_code_i % 16) & (plane_en_i % 16);
      e = pal_m[a];
    end
    if (mode_ctl_i[1]) return (col_sel_i / 4) * 64 + (col_sel_i % 4) * 16 + (e % 16);
    return (col_sel_i / 4) * 64 + e;
  endfunction

  function automatic int ref_diag(int x);
    case (plane_en_i / 16)
      0: return bitof(x, 2) * 2 + bitof(x, 0);
      1: return bitof(x, 5) * 2 + bitof(x, 4);
      2: return bitof(x, 3) * 2 + bitof(x, 1);
      default: return bitof(x, 7) * 2 + bitof(x, 6);
    endcase
  endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, int code, bit b);
    @(negedge clk);
    if (armed) begin
      chk("dac_idx", int'(dac_idx_o), e_idx);
      chk("dac_vld", int'(dac_vld_o), e_vld);
      chk("diag",    int'(diag_o),    e_diag);
    end
    pix_vld_i  = v;
    pix_code_i = code[7:0];
    border_i   = b;
    e_vld  = v;
    e_idx  = ref_idx();
    e_diag = ref_diag(e_idx);
    armed  = 1;
    @(posedge clk);
    #1;
  endtask

  task automatic rnd_pal();
    for (int i = 0; i < 16; i++) pal_m[i] = 6'($urandom_range(0, 63));
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pix_vld_i = 1; pix_code_i = 8'hA5; border_i = 0;
    mode_ctl_i = 2'b00; col_sel_i = 4'hF; plane_en_i = 6'h3F; ovs_color_i = 8'h3C;
    for (int i = 0; i < 16; i++) pal_m[i] = 6'((i * 37 + 5) % 64);
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    chk("reset dac_idx", int'(dac_idx_o), 0);
    chk("reset dac_vld", int'(dac_vld_o), 0);
    chk("reset diag",    int'(diag_o),    0);
    rst_n = 1;

    tag = "R2";
    for (int i = 0; i < 24; i++) step(i % 3 != 0, $urandom_range(0, 255), 0);

    tag = "R3";
    mode_ctl_i = 2'b00;
    for (int m = 0; m < 5; m++) begin
      int masks [5] = '{15, 5, 10, 0, 3};
      plane_en_i = 6'(masks[m] + 16 * $urandom_range(0, 3));
      for (int c = 0; c < 16; c++) step(1, c + 16 * $urandom_range(0, 15), 0);
    end

    tag = "R4";
    plane_en_i = 6'h0F;
    for (int i = 0; i < 20; i++) begin
      rnd_pal();
      col_sel_i = 4'($urandom_range(0, 15));
      step(1, $urandom_range(0, 255), 0);
    end

    tag = "R5";
    mode_ctl_i = 2'b10;
    for (int i = 0; i < 20; i++) begin
      col_sel_i = 4'($urandom_range(0, 15));
      step(1, $urandom_range(0, 255), 0);
    end

    tag = "R6";
    for (int c = 0; c < 16; c++) begin
      col_sel_i  = 4'(c);
      mode_ctl_i = (c % 2 == 0) ? 2'b00 : 2'b10;
      step(1, $urandom_range(0, 255), 0);
    end

    tag = "R7";
    mode_ctl_i = 2'b01;
    for (int i = 0; i < 24; i++) begin
      rnd_pal();
      col_sel_i  = 4'($urandom_range(0, 15));
      plane_en_i = 6'($urandom_range(0, 63));
      step(i % 4 != 3, $urandom_range(0, 255), 0);
    end

    tag = "R8";
    for (int i = 0; i < 24; i++) begin
      int modes [3] = '{0, 2, 1};
      mode_ctl_i  = 2'(modes[i % 3]);
      ovs_color_i = 8'($urandom_range(0, 255));
      col_sel_i   = 4'($urandom_range(0, 15));
      plane_en_i  = 6'($urandom_range(0, 63));
      step(1, $urandom_range(0, 255), 1);
    end

    tag = "R9";
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 12; i++) begin
        plane_en_i  = 6'(16 * s + $urandom_range(0, 15));
        mode_ctl_i  = 2'(i % 4 == 3 ? 1 : (i % 2) * 2);
        ovs_color_i = 8'($urandom_range(0, 255));
        col_sel_i   = 4'($urandom_range(0, 15));
        step(1, $urandom_range(0, 255), i % 2 == 1);
      end
    end

    step(0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule